// File: doc/BRIEF.md
# Interleaved Bank Refresh Sequencer

This block sits on the controller side of a multi-bank DRAM interface and produces refresh traffic in bursts. A single refresh request starts a burst with two waves. The first wave opens the same refresh row in every bank, one bank at a time from bank 0 upward. The command sent to the highest bank also tells the device to advance its internal refresh row pointer. The second wave closes the banks again in the same order, again one bank at a time.

Commands leave on a row-command slot under a valid/ready handshake. Three spacings are parameters, each counted in clock cycles from one accepted command to the next: between activates, between precharges, and between a bank's activate and its precharge. A recovery time after the last precharge is also a parameter. No new burst starts until that recovery time has passed.

The sequencer does not hold the slot on every cycle. In any cycle where it is not presenting a command, it raises `slot_free`, so the normal read/write arbiter can put its own row, column or precharge command in that slot. A request that arrives while a burst is in flight is remembered as one pending request.

The refresh request period must be no longer than the refresh interval divided by the number of rows per bank. That period is set by the requester and is not checked here.

Top module: `refresh_burst_seq`

## Requirements
- R1: After reset, `cmd_valid` is 0, `slot_free` is 1 and `cmd_op` is NOP (2'b00), and no command appears until a request arrives.
- R2: The activate wave issues one command per bank, to banks 0, 1, … NUM_BANKS-1 in that order. Every bank but the last gets the plain refresh-activate code 2'b01. The last bank gets the refresh-activate-and-increment code 2'b10.
- R3: Two consecutive accepted activates are at least T_RR cycles apart. When `cmd_ready` stays high, they are exactly T_RR cycles apart.
- R4: A bank's precharge is accepted no sooner than T_RAS cycles after that bank's activate was accepted.
- R5: After the activate wave, the sequencer issues precharge-refresh commands (code 2'b11), one per bank, to banks 0 through NUM_BANKS-1 in order. Consecutive precharges are at least T_PP cycles apart, and the first precharge is at least T_PP cycles after the last activate. With `cmd_ready` held high, each precharge is accepted at the later of these two bounds.
- R6: The first activate of a following burst is accepted at least T_RP cycles after the last precharge of the previous burst.
- R7: While `cmd_valid` is 1 and `cmd_ready` is 0, the command is held: on the next cycle `cmd_valid` is still 1, and `cmd_op` and `cmd_bank` are unchanged.
- R8: `slot_free` is 1 exactly when `cmd_valid` is 0. `cmd_op` reads NOP whenever `cmd_valid` is 0.
- R9: When a request is sampled with the sequencer idle, the activate to bank 0 is presented (`cmd_valid` = 1) in the very next cycle.
- R10: Any number of requests that arrive during a burst are merged into one pending request. That request starts exactly one more burst once recovery ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| refresh_req | input | 1 | Refresh burst request, sampled every cycle |
| cmd_ready | input | 1 | Row-command slot accepts the presented command |
| cmd_valid | output | 1 | A refresh command is presented |
| cmd_op | output | 2 | 00 NOP, 01 refresh activate, 10 refresh activate and increment, 11 refresh precharge |
| cmd_bank | output | $clog2(NUM_BANKS) | Target bank of the presented command |
| slot_free | output | 1 | Slot may be used by the read/write arbiter this cycle |

## Verification
Some rules are checked by assertions on every cycle. A handshake never lands while the spacing timer is still running. No bank is precharged before its own T_RAS timer has expired. The increment code only ever targets the last bank. A stalled command holds steady. The recovery window never presents a command.

Other behaviour can only be shown by the bench's scenarios. These scenarios cover the full order of both waves and the exact acceptance cycles under a steady ready signal. They also check the bounds under irregular back-pressure, the start latency from idle, and the merging of several mid-burst requests into exactly one further burst that begins no sooner than T_RP.

// File: rtl/refseq_pkg.sv
package refseq_pkg;

   typedef enum logic [1:0] {
      OP_NOP  = 2'b00,
      OP_REFA = 2'b01,
      OP_REFI = 2'b10,
      OP_REFP = 2'b11
   } ref_op_e;

   typedef enum logic [1:0] {
      S_IDLE,
      S_ACT,
      S_PRE,
      S_REC
   } seq_state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/refseq_gap_timer.sv
module refseq_gap_timer #(
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [TW-1:0] load_val,
   output logic          expired
);

   logic [TW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/refseq_bank_ras.sv
module refseq_bank_ras #(
   parameter int NB = 8,
   parameter int TW = 5,
   parameter int T_RAS = 10,
   localparam int BW = $clog2(NB)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          act_fire,
   input  logic [BW-1:0] act_bank,
   input  logic          pre_fire,
   input  logic [BW-1:0] pre_bank,
   output logic [NB-1:0] ras_done
);

   localparam logic [TW-1:0] RAS_LOAD = TW'(T_RAS - 1);

   for (genvar b = 0; b < NB; b++) begin : g_bank
      logic ld;
      assign ld = act_fire && (act_bank == BW'(b));
      refseq_gap_timer #(.TW(TW)) u_ras (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (ld),
         .load_val (RAS_LOAD),
         .expired  (ras_done[b])
      );
   end

   // no precharge before the addressed bank's own activate-to-precharge time
   assert_ras_R4: assert property (@(posedge clk) disable iff (!rst_n)
      pre_fire |-> ras_done[pre_bank]);

endmodule

// File: rtl/refresh_burst_seq.sv
module refresh_burst_seq
   import refseq_pkg::*;
#(
   parameter int NUM_BANKS = 8,
   parameter int T_RR  = 4,
   parameter int T_RAS = 10,
   parameter int T_PP  = 4,
   parameter int T_RP  = 5,
   localparam int BW = $clog2(NUM_BANKS)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          refresh_req,
   input  logic          cmd_ready,
   output logic          cmd_valid,
   output logic [1:0]    cmd_op,
   output logic [BW-1:0] cmd_bank,
   output logic          slot_free
);

   localparam int TMAX = max2(max2(T_RR, T_PP), max2(T_RAS, T_RP));
   localparam int TW = $clog2(TMAX + 1);
   localparam logic [BW-1:0] LAST_BANK = BW'(NUM_BANKS - 1);

   if (NUM_BANKS < 2) begin : g_bad_nb
      $error("NUM_BANKS must be at least 2");
   end
   if (T_RR < 1 || T_PP < 1 || T_RAS < 1 || T_RP < 1) begin : g_bad_t
      $error("all timing parameters must be at least 1");
   end

   seq_state_e    state_q;
   logic [BW-1:0] bank_q;
   logic          pend_q;
   logic          gap_ok;
   logic [NUM_BANKS-1:0] ras_ok;
   logic          hs;
   logic          last_bank;
   logic          gap_load;
   logic [TW-1:0] gap_val;
   ref_op_e       op_c;

   assign last_bank = (bank_q == LAST_BANK);

   always_comb begin
      cmd_valid = 1'b0;
      op_c      = OP_NOP;
      unique case (state_q)
         S_ACT: begin
            cmd_valid = gap_ok;
            op_c      = last_bank ? OP_REFI : OP_REFA;
         end
         S_PRE: begin
            cmd_valid = gap_ok && ras_ok[bank_q];
            op_c      = OP_REFP;
         end
         default: ;
      endcase
      if (!cmd_valid) op_c = OP_NOP;
   end

   assign hs        = cmd_valid && cmd_ready;
   assign cmd_op    = op_c;
   assign cmd_bank  = cmd_valid ? bank_q : '0;
   assign slot_free = !cmd_valid;

   always_comb begin
      gap_load = hs;
      gap_val  = TW'(T_RR - 1);
      if (state_q == S_ACT && last_bank) gap_val = TW'(T_PP - 1);
      if (state_q == S_PRE) gap_val = last_bank ? TW'(T_RP - 1) : TW'(T_PP - 1);
   end

   refseq_gap_timer #(.TW(TW)) u_gap (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (gap_load),
      .load_val (gap_val),
      .expired  (gap_ok)
   );

   refseq_bank_ras #(.NB(NUM_BANKS), .TW(TW), .T_RAS(T_RAS)) u_ras (
      .clk      (clk),
      .rst_n    (rst_n),
      .act_fire (hs && state_q == S_ACT),
      .act_bank (bank_q),
      .pre_fire (hs && state_q == S_PRE),
      .pre_bank (bank_q),
      .ras_done (ras_ok)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         bank_q  <= '0;
         pend_q  <= 1'b0;
      end else begin
         if (state_q != S_IDLE && refresh_req) pend_q <= 1'b1;
         unique case (state_q)
            S_IDLE: begin
               if (refresh_req || pend_q) begin
                  state_q <= S_ACT;
                  bank_q  <= '0;
                  pend_q  <= 1'b0;
               end
            end
            S_ACT: begin
               if (hs) begin
                  bank_q <= last_bank ? '0 : bank_q + 1'b1;
                  if (last_bank) state_q <= S_PRE;
               end
            end
            S_PRE: begin
               if (hs) begin
                  bank_q <= last_bank ? '0 : bank_q + 1'b1;
                  if (last_bank) state_q <= S_REC;
               end
            end
            S_REC: begin
               if (gap_ok) begin
                  if (pend_q || refresh_req) begin
                     state_q <= S_ACT;
                     pend_q  <= 1'b0;
                  end else begin
                     state_q <= S_IDLE;
                  end
               end
            end
            default: state_q <= S_IDLE;
         endcase
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_bank)));

   assert_refi_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == OP_REFI) |-> (cmd_bank == LAST_BANK));

   assert_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      hs |-> gap_ok);

   assert_rec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_REC) |-> (slot_free && cmd_op == OP_NOP));

   assert_nop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == S_IDLE) |-> (slot_free && !cmd_valid));

endmodule

// File: tb/sim_refresh_burst_seq.sv
module sim_refresh_burst_seq;

   localparam int NB    = 8;
   localparam int T_RR  = 2;
   localparam int T_RAS = 20;
   localparam int T_PP  = 3;
   localparam int T_RP  = 6;
   localparam int BW    = $clog2(NB);

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          refresh_req = 1'b0;
   logic          cmd_ready = 1'b0;
   logic          cmd_valid;
   logic [1:0]    cmd_op;
   logic [BW-1:0] cmd_bank;
   logic          slot_free;

   int n_tests = 0;
   int n_fail  = 0;

   always #10 clk = ~clk;

   refresh_burst_seq #(.NUM_BANKS(NB), .T_RR(T_RR), .T_RAS(T_RAS),
                       .T_PP(T_PP), .T_RP(T_RP)) u0 (
      .clk(clk), .rst_n(rst_n), .refresh_req(refresh_req), .cmd_ready(cmd_ready),
      .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_bank(cmd_bank), .slot_free(slot_free)
   );

   // handshake log, sampled at the falling edge
   int         cyc = 0;
   int         hs_cnt = 0;
   int         hs_t  [0:63];
   logic [1:0] hs_op [0:63];
   int         hs_bk [0:63];
   int         hold_err = 0;
   int         free_err = 0;
   logic       pv = 1'b0, pr = 1'b0;
   logic [1:0] pop = '0;
   logic [BW-1:0] pbk = '0;

   always @(negedge clk) begin
      cyc++;
      if (rst_n) begin
         if (pv && !pr && !(cmd_valid && cmd_op == pop && cmd_bank == pbk)) hold_err++;
         if (slot_free != !cmd_valid) free_err++;
         if (!cmd_valid && cmd_op != 2'b00) free_err++;
         if (cmd_valid && cmd_ready && hs_cnt < 64) begin
            hs_t[hs_cnt]  = cyc;
            hs_op[hs_cnt] = cmd_op;
            hs_bk[hs_cnt] = int'(cmd_bank);
            hs_cnt++;
         end
      end
      pv = cmd_valid; pr = cmd_ready; pop = cmd_op; pbk = cmd_bank;
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk); #5;
   endtask

   task automatic wait_hs(input int n, input int cap);
      for (int k = 0; k < cap && hs_cnt < n; k++) step();
   endtask

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   // verify one burst starting at log index b; exact timing when ready stayed high
   task automatic verify_burst(input int b, input bit exact);
      int e2 = 0, e3 = 0, e4 = 0, e5 = 0;
      for (int i = 0; i < NB; i++) begin
         if (hs_op[b+i] != ((i == NB-1) ? 2'b10 : 2'b01) || hs_bk[b+i] != i) e2++;
         if (i > 0) begin
            if (hs_t[b+i] - hs_t[b+i-1] < T_RR) e3++;
            if (exact && hs_t[b+i] - hs_t[b+i-1] != T_RR) e3++;
         end
         if (hs_op[b+NB+i] != 2'b11 || hs_bk[b+NB+i] != i) e5++;
         if (hs_t[b+NB+i] - hs_t[b+i] < T_RAS) e4++;
         if (hs_t[b+NB+i] - hs_t[b+NB+i-1] < T_PP) e5++;
         if (exact && hs_t[b+NB+i] != imax(hs_t[b+NB+i-1] + T_PP, hs_t[b+i] + T_RAS)) e5++;
      end
      check(e2 == 0, "R2 activate order/opcodes", e2, 0);
      check(e3 == 0, "R3 activate spacing", e3, 0);
      check(e4 == 0, "R4 activate-to-precharge", e4, 0);
      check(e5 == 0, "R5 precharge order/spacing", e5, 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) step();
      rst_n = 1'b1;
      cmd_ready = 1'b1;
      repeat (5) step();
      @(negedge clk);
      check(!cmd_valid && slot_free && cmd_op == 2'b00, "R1 reset outputs",
            {cmd_valid, slot_free, cmd_op}, 4'b0100);
      check(hs_cnt == 0, "R1 no command without request", hs_cnt, 0);
   endtask

   task automatic t_basic();
      hs_cnt = 0; hold_err = 0; free_err = 0;
      cmd_ready = 1'b1;
      refresh_req = 1'b1;
      step();
      refresh_req = 1'b0;
      @(negedge clk);
      check(cmd_valid && cmd_op == 2'b01 && cmd_bank == 0, "R9 start latency",
            {cmd_valid, cmd_op}, 3'b101);
      wait_hs(2*NB, 400);
      repeat (T_RP + 4) step();
      check(hs_cnt == 2*NB, "R2 burst length", hs_cnt, 2*NB);
      verify_burst(0, 1'b1);
      check(free_err == 0, "R8 slot_free/NOP", free_err, 0);
   endtask

   task automatic t_backpressure();
      logic [7:0] lfsr = 8'hA5;
      hs_cnt = 0; hold_err = 0; free_err = 0;
      refresh_req = 1'b1;
      step();
      refresh_req = 1'b0;
      for (int k = 0; k < 600 && hs_cnt < 2*NB; k++) begin
         lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
         cmd_ready = lfsr[0] & lfsr[2];
         step();
      end
      cmd_ready = 1'b1;
      repeat (T_RP + 4) step();
      check(hs_cnt == 2*NB, "R7 burst completes under back-pressure", hs_cnt, 2*NB);
      verify_burst(0, 1'b0);
      check(hold_err == 0, "R7 command held while stalled", hold_err, 0);
      check(free_err == 0, "R8 slot_free under back-pressure", free_err, 0);
   endtask

   task automatic t_pending();
      hs_cnt = 0;
      cmd_ready = 1'b1;
      refresh_req = 1'b1;
      step();
      refresh_req = 1'b0;
      repeat (4) step();
      refresh_req = 1'b1;
      step();
      refresh_req = 1'b0;
      repeat (10) step();
      refresh_req = 1'b1;
      step();
      refresh_req = 1'b0;
      wait_hs(4*NB, 800);
      repeat (200) step();
      check(hs_cnt == 4*NB, "R10 exactly one extra burst", hs_cnt, 4*NB);
      check(hs_t[2*NB] - hs_t[2*NB-1] >= T_RP, "R6 recovery before next burst",
            hs_t[2*NB] - hs_t[2*NB-1], T_RP);
      verify_burst(2*NB, 1'b1);
   endtask

   initial begin
      t_reset();
      t_basic();
      t_backpressure();
      t_pending();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      #(20 * 150000);
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", hs_cnt, 0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule